// File: doc/BRIEF.md
# Cyclic Parallel-Prefix Bus Arbiter

This block decides which of N requesters owns a single shared bus. Each requester drives one bit of a request vector and waits for its bit of the grant vector, which serves as the acknowledge. The winner is the first requesting position met when scanning upward from a rotating start position, wrapping from the top position back to position zero. A position wins when it requests and nothing earlier in that scan requests. That "still available" term is formed by a log-depth parallel-prefix OR network, not by a ripple chain through all N positions.

Ownership is held. Once a grant is issued it stays put, whatever the request vector does, until the owner pulses the release input. Arbitration happens only on a cycle where the bus is free. After each grant the start position moves to the slot just above the winner, so every active requester is served within N grants.

Top module: `cpp_bus_arbiter`

## Requirements
- R1: During and directly after synchronous active-low reset the grant vector is all zero and the start position is 0, so a full request vector on the first arbitration grants bit 0.
- R2: At most one bit of the grant vector is set in any cycle.
- R3: A grant bit that rises on a free bus belongs to a requester whose request bit was high in the preceding cycle.
- R4: On a free bus the winner is the first position with its request bit set, scanning upward from the start position and wrapping from position N-1 to position 0.
- R5: After each grant the start position becomes (winner + 1) modulo N.
- R6: While the bus is owned, the grant vector stays unchanged on every cycle without release, and changes to the request vector have no effect on it.
- R7: A release sampled while the bus is owned clears the grant vector on the next clock edge. A release on a free bus has no effect.
- R8: A request seen on a free bus is granted at the next clock edge. The edge that clears a grant never issues a new one, so a waiting requester is granted one cycle after the release takes effect.
- R9: A free bus with an all-zero request vector keeps the grant vector at zero and leaves the start position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N | Request vector, one bit per requester (bit i is requester i) |
| rel_i | input | 1 | Bus release pulse from the current owner |
| gnt_o | output | N | Registered one-hot grant vector (bit i is requester i) |

## Verification
The bench targets the wrap-around point of the cyclic scan. A start position near the top with requesters only at low positions must select the lowest of them; a scan that does not wrap would grant nothing, or would grant a high position. It drives a full request vector through N grant and release rounds, where a start position that fails to advance past the winner shows up as the same requester winning twice. It also changes the request vector and drops the owner's request while the bus is held, which catches a design that re-arbitrates without a release. Finally it issues releases on an idle bus and then a sparse request, which exposes a start position that drifts when nothing is granted.

// File: rtl/arb_pkg.sv
// Package: shared types for the cyclic bus arbiter.
// Assumes: nothing beyond standard SystemVerilog.
package arb_pkg;

    // Direction of a barrel rotation.
    typedef enum logic {
        ROT_DOWN = 1'b0,   // out[i] = in[(i + amt) mod N]
        ROT_UP   = 1'b1    // out[i] = in[(i - amt) mod N]
    } rot_dir_e;

endpackage

// File: rtl/arb_rotate.sv
// Module: arb_rotate
// Log-depth barrel rotator. Each stage rotates by 2^s when bit s of the
// amount is set. The direction is fixed by a parameter.
// Assumes: N is a power of two and at least 2.
module arb_rotate #(
    parameter int                N   = 8,
    parameter arb_pkg::rot_dir_e DIR = arb_pkg::ROT_DOWN,
    localparam int               LW  = $clog2(N)
) (
    input  logic [N-1:0]  din,
    input  logic [LW-1:0] amt,
    output logic [N-1:0]  dout
);

    logic [N-1:0] stage [0:LW];

    assign stage[0] = din;

    for (genvar s = 0; s < LW; s++) begin : g_stage
        localparam int D = 1 << s;
        logic [N-1:0] shifted;

        if (DIR == arb_pkg::ROT_DOWN) begin : g_down
            // Move each bit D places toward position 0, with wrap.
            assign shifted = {stage[s][D-1:0], stage[s][N-1:D]};
        end else begin : g_up
            // Move each bit D places toward position N-1, with wrap.
            assign shifted = {stage[s][N-D-1:0], stage[s][N-1:N-D]};
        end

        // Apply this stage only when its amount bit is set.
        assign stage[s+1] = amt[s] ? shifted : stage[s];
    end

    assign dout = stage[LW];

endmodule

// File: rtl/arb_prefix_chain.sv
// Module: arb_prefix_chain
// Fixed-priority chain with position 0 highest. Position i wins when it
// wants the bus and still sees the bus as available, meaning no lower
// position wants it. The "any lower position wants it" term is an inclusive
// OR scan built as a Kogge-Stone prefix network of log2(N) levels.
// Assumes: N is a power of two and at least 2.
module arb_prefix_chain #(
    parameter  int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0] want_i,
    output logic [N-1:0] got_o,
    output logic         any_o
);

    // lvl[s][i] = OR of want_i over positions max(0, i-2^s+1) .. i
    logic [N-1:0] lvl [0:LW];
    logic [N-1:0] avail;

    assign lvl[0] = want_i;

    for (genvar s = 0; s < LW; s++) begin : g_level
        localparam int D = 1 << s;
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (i >= D) begin : g_merge
                // Combine with the span that ends D positions lower.
                assign lvl[s+1][i] = lvl[s][i] | lvl[s][i-D];
            end else begin : g_pass
                // No lower span to combine with; carry the value up.
                assign lvl[s+1][i] = lvl[s][i];
            end
        end
    end

    // Position 0 always sees the bus available; position i sees it free
    // when no position below i wants it.
    assign avail = {~lvl[LW][N-2:0], 1'b1};

    // A grant goes to a position that both wants the bus and sees it free.
    assign got_o = want_i & avail;

    // The top of the scan tells whether anyone wants the bus at all.
    assign any_o = lvl[LW][N-1];

endmodule

// File: rtl/arb_onehot_enc.sv
// Module: arb_onehot_enc
// Turns a one-hot (or zero) vector into a binary index.
// Assumes: at most one input bit is set; an all-zero input gives 0.
module arb_onehot_enc #(
    parameter  int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  onehot_i,
    output logic [LW-1:0] idx_o
);

    // OR together the indices of all set bits.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_i[i]) begin
                idx_o = idx_o | LW'(i);
            end
        end
    end

endmodule

// File: rtl/cpp_bus_arbiter.sv
// Module: cpp_bus_arbiter (top)
// Online arbiter for one shared bus with a cyclic priority start.
// The request vector is rotated down by the start position, so that the
// start slot becomes position 0 of the prefix chain. The single winner is
// then rotated back up. This rotation is what turns the chain into a cyclic
// scan that wraps from N-1 to 0. The grant is registered and held until
// released. The start moves to just above each winner.
// Assumes: N is a power of two and at least 2; only the owner pulses rel_i.
module cpp_bus_arbiter #(
    parameter  int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         rel_i,
    output logic [N-1:0] gnt_o
);

    logic [N-1:0]  gnt_q;
    logic [LW-1:0] ptr_q;
    logic [N-1:0]  req_rot;
    logic [N-1:0]  got_rot;
    logic [N-1:0]  got;
    logic [LW-1:0] win_idx;
    logic          any_req;
    logic          bus_free;

    // Bring the start slot to position 0 of the chain.
    arb_rotate #(.N(N), .DIR(arb_pkg::ROT_DOWN)) u_rot_in (
        .din  (req_i),
        .amt  (ptr_q),
        .dout (req_rot)
    );

    // Log-depth priority chain over the rotated request vector.
    arb_prefix_chain #(.N(N)) u_chain (
        .want_i (req_rot),
        .got_o  (got_rot),
        .any_o  (any_req)
    );

    // Put the winning bit back at its true requester position.
    arb_rotate #(.N(N), .DIR(arb_pkg::ROT_UP)) u_rot_out (
        .din  (got_rot),
        .amt  (ptr_q),
        .dout (got)
    );

    // Index of the winner, used to advance the start position.
    arb_onehot_enc #(.N(N)) u_enc (
        .onehot_i (got),
        .idx_o    (win_idx)
    );

    // The bus is free when nobody holds a grant.
    assign bus_free = (gnt_q == '0);

    // Grant register and start pointer: arbitrate when free, clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
            ptr_q <= '0;
        end else if (bus_free) begin
            if (any_req) begin
                gnt_q <= got;
                ptr_q <= win_idx + 1'b1;
            end
        end else if (rel_i) begin
            gnt_q <= '0;
        end
    end

    assign gnt_o = gnt_q;

endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Property checks on the arbiter's ports, attached by bind.
// Assumes: rst_n is held low from time zero until the first clock edges.
module arb_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_i,
    input logic         rel_i,
    input logic [N-1:0] gnt_o
);

    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2

    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i != '0) |=> ((gnt_o != '0) && ((gnt_o & $past(req_i)) == gnt_o))); // R3

    AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !rel_i) |=> (gnt_o == $past(gnt_o))); // R6

    AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && rel_i) |=> (gnt_o == '0)); // R7

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0)); // R9

endmodule

bind cpp_bus_arbiter arb_checker #(.N(N)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .rel_i (rel_i),
    .gnt_o (gnt_o)
);

// File: tb/tb_cpp_bus_arbiter.sv
// Bench for cpp_bus_arbiter: directed scenarios, one task each, against a
// reference model of the rotating start position.
module tb_cpp_bus_arbiter;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         rel_i = 1'b0;
    logic [N-1:0] gnt_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_ptr  = 0;
    bit done     = 1'b0;

    cpp_bus_arbiter #(.N(N)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .rel_i (rel_i),
        .gnt_o (gnt_o)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    // Advance one edge and settle before sampling.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare the grant vector with an expected value.
    task automatic check(input string req, input logic [N-1:0] exp);
        n_checks++;
        if (gnt_o !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt_o actual=%b expected=%b", req, gnt_o, exp);
        end
    endtask

    // Model: first requesting slot scanning up from start, wrapping.
    function automatic int model_winner(input logic [N-1:0] mask, input int start);
        for (int k = 0; k < N; k++) begin
            if (mask[(start + k) % N]) return (start + k) % N;
        end
        return -1;
    endfunction

    // Request on a free bus, expect the model winner on the next edge.
    task automatic arbitrate(input string req, input logic [N-1:0] mask);
        int w;
        w = model_winner(mask, ref_ptr);
        req_i = mask;
        step();
        check(req, (N)'(1) << w);
        if ($countones(gnt_o) > 1) begin
            n_fail++;
            $display("FAIL R2: gnt_o actual=%b expected at most one bit", gnt_o);
        end
        ref_ptr = (w + 1) % N;
    endtask

    // Pulse release and expect the grant cleared.
    task automatic release_bus(input string req);
        rel_i = 1'b1;
        step();
        check(req, '0);
        rel_i = 1'b0;
    endtask

    // R1: reset state, then the first full request grants bit 0.
    task automatic t_reset();
        rst_n = 1'b0;
        req_i = '1;
        step();
        step();
        check("R1 in reset", '0);
        req_i = '0;
        rst_n = 1'b1;
        ref_ptr = 0;
        step();
        check("R1 after reset", '0);
        arbitrate("R1 first grant", '1);
        check("R1 bit0 wins", 8'b0000_0001);
        release_bus("R7 release");
    endtask

    // R4/R5: a full request vector is served round-robin.
    task automatic t_rotation();
        for (int k = 1; k <= N; k++) begin
            arbitrate("R5 rotation", '1);
            check("R4 round robin", (N)'(1) << (k % N));
            release_bus("R7 release");
        end
    endtask

    // R4: sparse patterns, including the wrap past N-1.
    task automatic t_sparse();
        arbitrate("R4 sparse a", 8'b0100_0100);
        arbitrate_release();
        arbitrate("R4 sparse b", 8'b1001_0000);
        arbitrate_release();
        // The start is now 5: only slots 0 and 1 request, so the scan wraps.
        arbitrate("R4 wrap", 8'b0000_0011);
        check("R4 wrap lowest", 8'b0000_0001);
        arbitrate_release();
    endtask

    task automatic arbitrate_release();
        release_bus("R7 release");
    endtask

    // R6: hold against request changes and the owner dropping its request.
    task automatic t_hold();
        logic [N-1:0] owner;
        arbitrate("R6 grant", 8'b0001_1000);
        owner = gnt_o;
        req_i = 8'b1110_0111;
        step();
        check("R6 other requests ignored", owner);
        req_i = '0;
        step();
        check("R6 owner drop ignored", owner);
        step();
        check("R6 still held", owner);
        release_bus("R7 release after hold");
    endtask

    // R8: a waiting requester is granted one cycle after the release.
    task automatic t_release_timing();
        arbitrate("R8 grant", 8'b0110_0000);
        req_i = 8'b0110_0000;
        rel_i = 1'b1;
        step();
        check("R8 release edge grants nothing", '0);
        rel_i = 1'b0;
        arbitrate("R8 next edge grant", 8'b0110_0000);
        release_bus("R7 release");
    endtask

    // R7/R9: release and silence on a free bus leave the start unchanged.
    task automatic t_idle();
        req_i = '0;
        rel_i = 1'b1;
        step();
        check("R7 idle release", '0);
        step();
        check("R7 idle release again", '0);
        rel_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R9 idle", '0);
        end
        arbitrate("R9 start unchanged", '1);
        release_bus("R7 release");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_rotation();
        t_sparse();
        t_hold();
        t_release_timing();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule